// File: doc/BRIEF.md
# Dual-Bus Column Data Formatter

This block sits between the dual-pixel video path of a panel timing controller and the reduced-swing column-driver pads. Each clock it accepts one front and one back RGB pixel with 8 bits per colour. It turns every colour into four lanes that carry one bit on the rising clock edge and one on the falling edge. The rising-edge and falling-edge halves come out as separate lane vectors, and the pad layer serialises them against the forwarded clock.

A line-active input marks the visible part of each line. Data is carried through a fixed pipeline of `LAT` register stages. A one-clock column start pulse leaves the block in the same cycle as the first word of each line. A colour-depth select picks 8-bit or 6-bit packing. A mount-orientation select mirrors the lane order for panels mounted top or bottom. A 3-bit pad skew code is sampled only while the line is blank and is held static for the pad layer.

Top module: `rsds_col_fmt`

## Requirements
- R1: While reset is asserted, all lane outputs, the column start pulse and the skew output are zero.
- R2: Pixel data, depth select and swap select sampled at clock edge t take effect on the outputs right after edge t+LAT-1. LAT defaults to 3.
- R3: With depth8=1 and mount_swap=0, lane i of a colour carries colour bit 2i on the rising half and colour bit 2i+1 on the falling half. In each 12-bit bus vector, red is bits [3:0], green is bits [7:4] and blue is bits [11:8]. In each 24-bit pixel, red is [7:0], green is [15:8] and blue is [23:16].
- R4: With depth8=0, the colour value is bits [5:0] of each component. Lanes 0..2 follow the R3 bit rule. Lane 3 is zero on both halves, and bits [7:6] have no effect.
- R5: With mount_swap=1, output lane i of each colour carries what lane 3-i would carry with mount_swap=0, for both halves and both depths.
- R6: col_start is high for exactly one clock, in the output cycle that holds the first active word of a line. That is the output cycle whose sample had line_active=1 while the sample before it had line_active=0.
- R7: In every output cycle whose sample had line_active=0, all four lane vectors are zero.
- R8: skew_pad takes the value of skew_sel at a clock edge where line_active is 0, one clock later. Edges where line_active is 1 leave skew_pad unchanged.
- R9: The front and back buses are formatted independently from front_pix and back_pix. Both forwarded clocks follow clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_active | input | 1 | High during the visible part of a line |
| depth8 | input | 1 | 1 selects 8-bit packing, 0 selects 6-bit |
| mount_swap | input | 1 | 1 mirrors the lane order within each colour |
| skew_sel | input | 3 | Requested pad skew code |
| front_pix | input | 24 | Front pixel {B,G,R} |
| back_pix | input | 24 | Back pixel {B,G,R} |
| fwd_clk_f | output | 1 | Forwarded clock for the front bus |
| fwd_clk_b | output | 1 | Forwarded clock for the back bus |
| f_rise | output | 12 | Front bus, rising-edge lane bits |
| f_fall | output | 12 | Front bus, falling-edge lane bits |
| b_rise | output | 12 | Back bus, rising-edge lane bits |
| b_fall | output | 12 | Back bus, falling-edge lane bits |
| col_start | output | 1 | One-clock column start pulse |
| skew_pad | output | 3 | Held skew code for the pad layer |

## Verification
The column start pulse and the skew capture meet at the clock where line_active rises. On that edge a new skew code must be refused while the first word of the line enters the pipeline. The bench drives a fresh random skew code on every cycle, so every line start also carries a skew change. Lines as short as one clock with one-clock gaps make start pulses dense. A behavioural model keeps a queue of past samples and a separately held skew value, and both outputs are compared against it on every clock.

// File: rtl/rsds_fmt_pkg.sv
package rsds_fmt_pkg;
    localparam int unsigned COMP_W_DEF = 8;
    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned NCOL       = 3;
    localparam int unsigned NBUS       = 2;

    typedef enum logic {
        DEPTH6 = 1'b0,
        DEPTH8 = 1'b1
    } depth_e;
endpackage

// File: rtl/rsds_align_pipe.sv
module rsds_align_pipe #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rsds_half_split.sv
module rsds_half_split
    import rsds_fmt_pkg::*;
#(
    parameter int unsigned COMP_W = COMP_W_DEF,
    parameter int unsigned LANES  = LANES_DEF
) (
    input  logic [COMP_W-1:0] comp,
    input  depth_e            depth,
    input  logic              swap,
    output logic [LANES-1:0]  rise,
    output logic [LANES-1:0]  fall
);
    logic [LANES-1:0] even_b;
    logic [LANES-1:0] odd_b;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (depth == DEPTH6 && i == LANES - 1) begin
                even_b[i] = 1'b0;
                odd_b[i]  = 1'b0;
            end else begin
                even_b[i] = comp[2*i];
                odd_b[i]  = comp[2*i+1];
            end
        end
        for (int i = 0; i < LANES; i++) begin
            rise[i] = swap ? even_b[LANES-1-i] : even_b[i];
            fall[i] = swap ? odd_b[LANES-1-i]  : odd_b[i];
        end
    end
endmodule

// File: rtl/rsds_skew_hold.sv
module rsds_skew_hold #(
    parameter int unsigned SKEW_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank,
    input  logic [SKEW_W-1:0] skew_in,
    output logic [SKEW_W-1:0] skew_out
);
    logic [SKEW_W-1:0] skew_d;
    logic [SKEW_W-1:0] skew_q;

    always_comb begin
        skew_d = blank ? skew_in : skew_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skew_q <= '0;
        end else begin
            skew_q <= skew_d;
        end
    end

    assign skew_out = skew_q;
endmodule

// File: rtl/rsds_col_fmt.sv
module rsds_col_fmt
    import rsds_fmt_pkg::*;
#(
    parameter int unsigned COMP_W = COMP_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned SKEW_W = 3,
    parameter int unsigned LAT    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_active,
    input  logic                     depth8,
    input  logic                     mount_swap,
    input  logic [SKEW_W-1:0]        skew_sel,
    input  logic [NCOL*COMP_W-1:0]   front_pix,
    input  logic [NCOL*COMP_W-1:0]   back_pix,
    output logic                     fwd_clk_f,
    output logic                     fwd_clk_b,
    output logic [NCOL*LANES-1:0]    f_rise,
    output logic [NCOL*LANES-1:0]    f_fall,
    output logic [NCOL*LANES-1:0]    b_rise,
    output logic [NCOL*LANES-1:0]    b_fall,
    output logic                     col_start,
    output logic [SKEW_W-1:0]        skew_pad
);
    localparam int unsigned PIX_W   = NCOL * COMP_W;
    localparam int unsigned BUS_W   = NCOL * LANES;
    localparam int unsigned PIPE_W  = 3 + NBUS * PIX_W;
    localparam int unsigned STAGES  = (LAT > 1) ? LAT - 1 : 1;

    typedef struct packed {
        logic                   act;
        logic                   d8;
        logic                   sw;
        logic [NBUS*PIX_W-1:0]  pix;
    } word_t;

    typedef struct packed {
        logic              act;
        logic              start;
        logic [BUS_W-1:0]  fr;
        logic [BUS_W-1:0]  ff;
        logic [BUS_W-1:0]  br;
        logic [BUS_W-1:0]  bf;
    } out_t;

    word_t head_w;
    word_t tail_w;
    logic [PIPE_W-1:0] tail_vec;

    assign head_w = '{act: line_active, d8: depth8, sw: mount_swap,
                      pix: {back_pix, front_pix}};

    rsds_align_pipe #(.W(PIPE_W), .STAGES(STAGES)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (head_w),
        .dout  (tail_vec)
    );

    assign tail_w = word_t'(tail_vec);

    logic [NBUS*BUS_W-1:0] rise_w;
    logic [NBUS*BUS_W-1:0] fall_w;
    depth_e tail_depth;

    assign tail_depth = tail_w.d8 ? DEPTH8 : DEPTH6;

    for (genvar gb = 0; gb < NBUS; gb++) begin : g_bus
        for (genvar gc = 0; gc < NCOL; gc++) begin : g_col
            rsds_half_split #(.COMP_W(COMP_W), .LANES(LANES)) u_split (
                .comp  (tail_w.pix[gb*PIX_W + gc*COMP_W +: COMP_W]),
                .depth (tail_depth),
                .swap  (tail_w.sw),
                .rise  (rise_w[gb*BUS_W + gc*LANES +: LANES]),
                .fall  (fall_w[gb*BUS_W + gc*LANES +: LANES])
            );
        end
    end

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d = '0;
        out_d.act = tail_w.act;
        out_d.start = tail_w.act && !out_q.act;
        if (tail_w.act) begin
            out_d.fr = rise_w[0 +: BUS_W];
            out_d.ff = fall_w[0 +: BUS_W];
            out_d.br = rise_w[BUS_W +: BUS_W];
            out_d.bf = fall_w[BUS_W +: BUS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    rsds_skew_hold #(.SKEW_W(SKEW_W)) u_skew (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank    (!line_active),
        .skew_in  (skew_sel),
        .skew_out (skew_pad)
    );

    assign fwd_clk_f = clk;
    assign fwd_clk_b = clk;
    assign f_rise    = out_q.fr;
    assign f_fall    = out_q.ff;
    assign b_rise    = out_q.br;
    assign b_fall    = out_q.bf;
    assign col_start = out_q.start;
endmodule

// File: rtl/rsds_col_fmt_chk.sv
module rsds_col_fmt_chk #(
    parameter int unsigned BUS_W  = 12,
    parameter int unsigned SKEW_W = 3,
    parameter int unsigned LAT    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_active,
    input logic [SKEW_W-1:0] skew_sel,
    input logic [SKEW_W-1:0] skew_pad,
    input logic              col_start,
    input logic [BUS_W-1:0]  f_rise,
    input logic [BUS_W-1:0]  f_fall,
    input logic [BUS_W-1:0]  b_rise,
    input logic [BUS_W-1:0]  b_fall
);
    logic [LAT:0] act_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_hist <= '0;
        end else begin
            act_hist <= {act_hist[LAT-1:0], line_active};
        end
    end

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        col_start == (act_hist[LAT-1] && !act_hist[LAT])); // R6

    AST_START_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        col_start |=> !col_start); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !act_hist[LAT-1] |-> (f_rise == '0 && f_fall == '0 && b_rise == '0 && b_fall == '0)); // R7

    AST_SKEW_BLANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        line_active |=> $stable(skew_pad)); // R8

    AST_SKEW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_active |=> skew_pad == $past(skew_sel)); // R8
endmodule

bind rsds_col_fmt rsds_col_fmt_chk #(
    .BUS_W  (NCOL*LANES),
    .SKEW_W (SKEW_W),
    .LAT    (LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_active (line_active),
    .skew_sel    (skew_sel),
    .skew_pad    (skew_pad),
    .col_start   (col_start),
    .f_rise      (f_rise),
    .f_fall      (f_fall),
    .b_rise      (b_rise),
    .b_fall      (b_fall)
);

// File: tb/tb_rsds_col_fmt.sv
`timescale 1ns/1ps
module tb_rsds_col_fmt;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_active = 1'b0;
    logic        depth8 = 1'b1;
    logic        mount_swap = 1'b0;
    logic [2:0]  skew_sel = 3'd0;
    logic [23:0] front_pix = '0;
    logic [23:0] back_pix = '0;
    logic        fwd_clk_f, fwd_clk_b, col_start;
    logic [11:0] f_rise, f_fall, b_rise, b_fall;
    logic [2:0]  skew_pad;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rsds_col_fmt #(.LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .line_active(line_active), .depth8(depth8),
        .mount_swap(mount_swap), .skew_sel(skew_sel), .front_pix(front_pix),
        .back_pix(back_pix), .fwd_clk_f(fwd_clk_f), .fwd_clk_b(fwd_clk_b),
        .f_rise(f_rise), .f_fall(f_fall), .b_rise(b_rise), .b_fall(b_fall),
        .col_start(col_start), .skew_pad(skew_pad)
    );

    typedef struct {
        bit        de;
        bit        d8;
        bit        sw;
        bit [23:0] fp;
        bit [23:0] bp;
    } smp_t;

    smp_t hist[$];
    bit   prev_de;
    bit [2:0] skew_m;
    bit [11:0] e_fr, e_ff, e_br, e_bf;
    bit   e_hs;
    bit   e_de, e_d8, e_sw;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [11:0] lanes(bit [23:0] pix, bit d8, bit sw, bit odd);
        bit [11:0] r = '0;
        for (int c = 0; c < 3; c++) begin
            for (int l = 0; l < 4; l++) begin
                int src = sw ? 3 - l : l;
                if (d8 || src != 3) r[c*4+l] = pix[c*8 + 2*src + (odd ? 1 : 0)];
            end
        end
        return r;
    endfunction

    task automatic step(input bit de, input bit d8, input bit sw, input bit [2:0] sk,
                        input bit [23:0] fp, input bit [23:0] bp);
        smp_t s;
        smp_t z;
        string tg;
        line_active = de; depth8 = d8; mount_swap = sw; skew_sel = sk;
        front_pix = fp; back_pix = bp;
        @(posedge clk);
        s.de = line_active; s.d8 = depth8; s.sw = mount_swap;
        s.fp = front_pix; s.bp = back_pix;
        hist.push_back(s);
        if (hist.size() > LAT) void'(hist.pop_front());
        z = '{de: 0, d8: 0, sw: 0, fp: 0, bp: 0};
        if (hist.size() >= LAT) z = hist[hist.size()-LAT];
        e_de = z.de; e_d8 = z.d8; e_sw = z.sw;
        e_hs = z.de && !prev_de;
        prev_de = z.de;
        if (!s.de) skew_m = skew_sel;
        e_fr = z.de ? lanes(z.fp, z.d8, z.sw, 0) : '0;
        e_ff = z.de ? lanes(z.fp, z.d8, z.sw, 1) : '0;
        e_br = z.de ? lanes(z.bp, z.d8, z.sw, 0) : '0;
        e_bf = z.de ? lanes(z.bp, z.d8, z.sw, 1) : '0;
        @(negedge clk);
        if (!e_de) tg = "R7";
        else if (e_sw) tg = e_d8 ? "R2 R5 R3" : "R2 R5 R4";
        else tg = e_d8 ? "R2 R3" : "R2 R4";
        chk({tg, " front"}, {f_rise, f_fall}, {e_fr, e_ff});
        chk({tg, " R9 back"}, {b_rise, b_fall}, {e_br, e_bf});
        chk("R6 col_start", col_start, e_hs);
        chk("R8 skew_pad", skew_pad, skew_m);
        chk("R9 fwd clocks", {fwd_clk_f, fwd_clk_b}, 2'b00);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit d8, sw;
        rst_n = 1'b0;
        line_active = 1'b1; skew_sel = 3'd5; front_pix = 24'hFFFFFF; back_pix = 24'hFFFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 lanes in reset", {f_rise, f_fall, b_rise, b_fall}, '0);
        chk("R1 start/skew in reset", {col_start, skew_pad}, '0);
        line_active = 1'b0;
        rst_n = 1'b1;
        hist.delete(); prev_de = 0; skew_m = 0;

        // directed: 8-bit, unswapped, known pattern, then 6-bit with top bits set
        step(0, 1, 0, 3'd1, 24'h0, 24'h0);
        step(1, 1, 0, 3'd2, 24'hA5_3C_81, 24'h5A_C3_18);
        step(1, 0, 0, 3'd3, 24'hFF_FF_FF, 24'hC0_C0_C0);
        step(1, 1, 1, 3'd4, 24'h12_34_56, 24'h65_43_21);
        step(0, 0, 1, 3'd6, 24'h3F_3F_3F, 24'h0);
        step(1, 0, 1, 3'd7, 24'h15_2A_3F, 24'hFF_00_FF);
        for (int i = 0; i < LAT + 2; i++) step(0, 1, 0, 3'd0, 24'h0, 24'h0);

        // single-clock lines with single-clock gaps
        for (int i = 0; i < 20; i++) begin
            step(1, 1'($urandom), 1'($urandom), 3'($urandom), 24'($urandom), 24'($urandom));
            step(0, 1'($urandom), 1'($urandom), 3'($urandom), 24'($urandom), 24'($urandom));
        end

        // random lines, skew changing every clock, occasional mid-line mode flips
        for (int ln = 0; ln < 150; ln++) begin
            int len = 1 + int'($urandom % 30);
            int gap = 1 + int'($urandom % 5);
            d8 = 1'($urandom); sw = 1'($urandom);
            for (int k = 0; k < len; k++) begin
                if ($urandom % 8 == 0) d8 = ~d8;
                if ($urandom % 8 == 0) sw = ~sw;
                step(1, d8, sw, 3'($urandom), 24'($urandom), 24'($urandom));
            end
            for (int k = 0; k < gap; k++)
                step(0, 1'($urandom), 1'($urandom), 3'($urandom), 24'($urandom), 24'($urandom));
        end
        for (int i = 0; i < LAT + 2; i++) step(0, 1, 0, 3'd0, 24'h0, 24'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule